// File: doc/BRIEF.md
# Two-Word Load/Store Transfer Sequencer

This block sits between a coprocessor register file with 64-bit entries and a 32-bit memory data bus. During a load or store instruction the host presents one bus cycle per clock on `req_i`. A data cycle moves one word. Any other cycle type ends the transfer and restarts the sequence. A long access moves two words in consecutive data cycles. A short access moves a single word.

The half of the register that each beat uses depends on the byte-order input. A short load places a float in the upper half, or sign-extends an integer into all 64 bits. A short store reads the upper half for a float and the lower half for an integer. The block answers every presented cycle with either DONE or INC. INC asks the host to step the address and present the next word. The block does not generate addresses.

Top module: `dword_xfer_seq`

## Requirements
- R1: After reset, or a reset applied in the middle of a long access, the next long data cycle is treated as the first beat and answers INC.
- R2: A presented cycle with `data_cyc_i` = 0 answers DONE with no INC and no write enable, and the next long data cycle is a first beat again.
- R3: On a long access the first data beat answers INC only and the second answers DONE only. DONE and INC are never high together.
- R4: On a long load the first beat writes the upper half (`wr_en_o` = 2'b10) when `big_endian_i` = 1, and the lower half (2'b01) when it is 0. The second beat writes the other half. Each beat carries the bus word into the enabled half.
- R5: On a long store the first beat drives the upper half `reg_rdata_i[63:32]` onto `bus_wdata_o` when big-endian, and the lower half `[31:0]` otherwise. The second beat drives the other half.
- R6: A short float load (`float_i` = 1) writes only the upper half (`wr_en_o` = 2'b10) with the bus word.
- R7: A short integer load (`float_i` = 0) asserts both enables (2'b11). It writes the bus word to the lower half and copies bit 31 of that word into all 32 upper bits.
- R8: A short float store drives the upper half of `reg_rdata_i` onto `bus_wdata_o`. A short integer store drives the lower half.
- R9: With `req_i` = 0 there is no DONE, no INC and no write enable, and the beat position holds. A long access may therefore pause between its beats.
- R10: A short data cycle answers DONE and leaves the next long data cycle as a first beat.
- R11: `wr_en_o` stays 2'b00 on every store cycle (`store_i` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | A bus cycle is presented this clock |
| data_cyc_i | input | 1 | 1 = data cycle, 0 = any other cycle type |
| store_i | input | 1 | 1 = store (register to bus), 0 = load |
| long_i | input | 1 | 1 = two-word access, 0 = one word |
| float_i | input | 1 | Short access format: 1 = float, 0 = integer |
| big_endian_i | input | 1 | 1 = big-endian word order on long accesses |
| bus_rdata_i | input | 32 | Word read from memory (loads) |
| reg_rdata_i | input | 64 | Current register contents (stores) |
| wr_data_o | output | 64 | Register write data |
| wr_en_o | output | 2 | Write enable per half: bit 1 upper, bit 0 lower |
| bus_wdata_o | output | 32 | Word written to memory (stores) |
| done_o | output | 1 | Transfer complete for this cycle |
| inc_o | output | 1 | Step the address and present the next word |

## Verification
The assertions assume that the access type is held steady while a cycle is presented. They also assume that the host presents the second word only after it has seen INC. They do not assume that every long access completes. A non-data cycle, a short access or a reset may interrupt a long access. The stimulus produces all of these interruptions on purpose, both in directed sequences and in a long random run. The random run changes the access type freely from one cycle to the next and inserts idle cycles between beats. A behavioural model in the bench tracks the beat position and compares every output on every clock.

// File: rtl/dword_xfer_pkg.sv
`timescale 1ns/1ps
package dword_xfer_pkg;
  typedef enum logic {
    LANE_LO = 1'b0,
    LANE_HI = 1'b1
  } lane_e;
endpackage

// File: rtl/dword_xfer_beat_ctr.sv
`timescale 1ns/1ps
module dword_xfer_beat_ctr #(
  parameter int BEATS = 2,
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             adv_i,
  output logic [CNT_W-1:0] beat_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  assign last_o = (cnt_q == CNT_W'(BEATS - 1));
  assign beat_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (adv_i)   cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/dword_xfer_lane_sel.sv
`timescale 1ns/1ps
module dword_xfer_lane_sel
  import dword_xfer_pkg::*;
#(
  parameter int CNT_W = 1
) (
  input  logic             long_i,
  input  logic             float_i,
  input  logic             big_endian_i,
  input  logic [CNT_W-1:0] beat_i,
  output lane_e            lane_o
);
  // long: first beat goes to the high half on big-endian, order swaps after
  always_comb begin
    if (long_i) lane_o = lane_e'(big_endian_i ^ beat_i[0]);
    else        lane_o = float_i ? LANE_HI : LANE_LO;
  end
endmodule

// File: rtl/dword_xfer_load_fmt.sv
`timescale 1ns/1ps
module dword_xfer_load_fmt
  import dword_xfer_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int REG_W = 2 * WORD_W
) (
  input  logic              en_i,
  input  lane_e             lane_i,
  input  logic              sext_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [REG_W-1:0]  wr_data_o,
  output logic [1:0]        wr_en_o
);
  always_comb begin
    wr_data_o = '0;
    wr_en_o   = 2'b00;
    if (en_i) begin
      if (sext_i) begin
        wr_data_o = {{WORD_W{word_i[WORD_W-1]}}, word_i};
        wr_en_o   = 2'b11;
      end else begin
        wr_data_o = {word_i, word_i};
        wr_en_o   = (lane_i == LANE_HI) ? 2'b10 : 2'b01;
      end
    end
  end
endmodule

// File: rtl/dword_xfer_store_mux.sv
`timescale 1ns/1ps
module dword_xfer_store_mux
  import dword_xfer_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int REG_W = 2 * WORD_W
) (
  input  logic              en_i,
  input  lane_e             lane_i,
  input  logic [REG_W-1:0]  reg_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    if (!en_i)                 word_o = '0;
    else if (lane_i == LANE_HI) word_o = reg_i[REG_W-1:WORD_W];
    else                       word_o = reg_i[WORD_W-1:0];
  end
endmodule

// File: rtl/dword_xfer_seq.sv
`timescale 1ns/1ps
module dword_xfer_seq
  import dword_xfer_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int REG_W = 2 * WORD_W,
  localparam int BEATS = 2,
  localparam int CNT_W = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              data_cyc_i,
  input  logic              store_i,
  input  logic              long_i,
  input  logic              float_i,
  input  logic              big_endian_i,
  input  logic [WORD_W-1:0] bus_rdata_i,
  input  logic [REG_W-1:0]  reg_rdata_i,
  output logic [REG_W-1:0]  wr_data_o,
  output logic [1:0]        wr_en_o,
  output logic [WORD_W-1:0] bus_wdata_o,
  output logic              done_o,
  output logic              inc_o
);
  logic             data_beat;
  logic             finish;
  logic             last_beat;
  logic [CNT_W-1:0] beat;
  lane_e            lane;

  assign data_beat = req_i & data_cyc_i;
  // any non-data cycle, short access or final long beat closes the transfer
  assign finish    = req_i & (~data_cyc_i | ~long_i | last_beat);
  assign done_o    = finish;
  assign inc_o     = data_beat & long_i & ~last_beat;

  dword_xfer_beat_ctr #(.BEATS(BEATS)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (finish),
    .adv_i   (data_beat & long_i),
    .beat_o  (beat),
    .last_o  (last_beat)
  );

  dword_xfer_lane_sel #(.CNT_W(CNT_W)) u_lane (
    .long_i       (long_i),
    .float_i      (float_i),
    .big_endian_i (big_endian_i),
    .beat_i       (beat),
    .lane_o       (lane)
  );

  dword_xfer_load_fmt #(.WORD_W(WORD_W)) u_ld (
    .en_i      (data_beat & ~store_i),
    .lane_i    (lane),
    .sext_i    (~long_i & ~float_i),
    .word_i    (bus_rdata_i),
    .wr_data_o (wr_data_o),
    .wr_en_o   (wr_en_o)
  );

  dword_xfer_store_mux #(.WORD_W(WORD_W)) u_st (
    .en_i   (data_beat & store_i),
    .lane_i (lane),
    .reg_i  (reg_rdata_i),
    .word_o (bus_wdata_o)
  );
endmodule

// File: rtl/dword_xfer_seq_chk.sv
`timescale 1ns/1ps
module dword_xfer_seq_chk #(
  parameter int WORD_W = 32,
  localparam int REG_W = 2 * WORD_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              data_cyc_i,
  input logic              store_i,
  input logic              long_i,
  input logic              float_i,
  input logic              big_endian_i,
  input logic [WORD_W-1:0] bus_rdata_i,
  input logic [REG_W-1:0]  reg_rdata_i,
  input logic [REG_W-1:0]  wr_data_o,
  input logic [1:0]        wr_en_o,
  input logic [WORD_W-1:0] bus_wdata_o,
  input logic              done_o,
  input logic              inc_o
);
  AST_HS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && inc_o)); // R3

  AST_NONDATA_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !data_cyc_i) |-> (done_o && !inc_o && wr_en_o == 2'b00)); // R2

  AST_SECOND_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_o |=> (!(req_i && data_cyc_i && long_i) || done_o)); // R3

  AST_LONG_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && data_cyc_i && long_i && !store_i) |-> $countones(wr_en_o) == 1); // R4

  AST_FIRST_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_o && !store_i) |-> wr_en_o == (big_endian_i ? 2'b10 : 2'b01)); // R4

  AST_SEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && data_cyc_i && !long_i && !store_i && !float_i) |->
      (wr_en_o == 2'b11 && wr_data_o[REG_W-1:WORD_W] == {WORD_W{bus_rdata_i[WORD_W-1]}}
       && wr_data_o[WORD_W-1:0] == bus_rdata_i)); // R7

  AST_SHORT_INT_ST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && data_cyc_i && !long_i && store_i && !float_i) |->
      bus_wdata_o == reg_rdata_i[WORD_W-1:0]); // R8

  AST_STORE_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_i |-> wr_en_o == 2'b00); // R11

  AST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (!done_o && !inc_o && wr_en_o == 2'b00)); // R9
endmodule

bind dword_xfer_seq dword_xfer_seq_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .data_cyc_i   (data_cyc_i),
  .store_i      (store_i),
  .long_i       (long_i),
  .float_i      (float_i),
  .big_endian_i (big_endian_i),
  .bus_rdata_i  (bus_rdata_i),
  .reg_rdata_i  (reg_rdata_i),
  .wr_data_o    (wr_data_o),
  .wr_en_o      (wr_en_o),
  .bus_wdata_o  (bus_wdata_o),
  .done_o       (done_o),
  .inc_o        (inc_o)
);

// File: tb/dword_xfer_seq_bench.sv
`timescale 1ns/1ps
module dword_xfer_seq_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, data_cyc_i = 1'b0, store_i = 1'b0, long_i = 1'b0;
  logic        float_i = 1'b0, big_endian_i = 1'b0;
  logic [31:0] bus_rdata_i = '0;
  logic [63:0] reg_rdata_i = '0;
  logic [63:0] wr_data_o;
  logic [1:0]  wr_en_o;
  logic [31:0] bus_wdata_o;
  logic        done_o, inc_o;

  int n_chk = 0;
  int n_fail = 0;
  int m_beat = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dword_xfer_seq u_dword_xfer_seq (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .data_cyc_i(data_cyc_i),
    .store_i(store_i), .long_i(long_i), .float_i(float_i),
    .big_endian_i(big_endian_i), .bus_rdata_i(bus_rdata_i),
    .reg_rdata_i(reg_rdata_i), .wr_data_o(wr_data_o), .wr_en_o(wr_en_o),
    .bus_wdata_o(bus_wdata_o), .done_o(done_o), .inc_o(inc_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // one presented clock: drive at negedge, compare before posedge, advance model
  task automatic cyc(input bit rq, input bit dc, input bit st, input bit lg,
                     input bit fl, input bit be, input logic [31:0] bus,
                     input logic [63:0] rv);
    bit e_done, e_inc, hi;
    logic [1:0] e_en;
    logic [63:0] e_data;
    logic [31:0] e_wd;
    string tg, tg_en, tg_wd;
    int nxt;
    @(negedge clk);
    req_i = rq; data_cyc_i = dc; store_i = st; long_i = lg;
    float_i = fl; big_endian_i = be; bus_rdata_i = bus; reg_rdata_i = rv;
    #3;
    e_done = 0; e_inc = 0; e_en = 2'b00; e_data = '0; e_wd = '0;
    nxt = m_beat; tg = "R9"; tg_en = "R9"; tg_wd = "R9";
    if (!rq) begin
      nxt = m_beat;
    end else if (!dc) begin
      e_done = 1; nxt = 0; tg = "R2"; tg_en = "R2";
    end else if (lg) begin
      e_inc = (m_beat == 0); e_done = !e_inc;
      hi = (m_beat == 0) ? be : !be;
      nxt = e_inc ? 1 : 0;
      tg = (m_beat == 0) ? "R1" : "R3";
      tg_en = "R4"; tg_wd = "R5";
      if (!st) begin e_en = hi ? 2'b10 : 2'b01; e_data = {bus, bus}; end
      else e_wd = hi ? rv[63:32] : rv[31:0];
    end else begin
      e_done = 1; nxt = 0; tg = "R10";
      if (!st) begin
        if (fl) begin e_en = 2'b10; e_data = {bus, 32'h0}; tg_en = "R6"; end
        else begin e_en = 2'b11; e_data = {{32{bus[31]}}, bus}; tg_en = "R7"; end
      end else begin
        e_wd = fl ? rv[63:32] : rv[31:0]; tg_wd = "R8";
      end
    end
    if (st) tg_en = "R11";
    chk(tg, "done", 64'(done_o), 64'(e_done));
    chk(tg, "inc", 64'(inc_o), 64'(e_inc));
    chk(tg_en, "wr_en", 64'(wr_en_o), 64'(e_en));
    if (e_en[1]) chk(tg_en, "wr_hi", 64'(wr_data_o[63:32]), 64'(e_data[63:32]));
    if (e_en[0]) chk(tg_en, "wr_lo", 64'(wr_data_o[31:0]), 64'(e_data[31:0]));
    if (rq && dc && st) chk(tg_wd, "bus_wdata", 64'(bus_wdata_o), 64'(e_wd));
    @(posedge clk);
    m_beat = nxt;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; req_i = 1'b0;
    #3;
    chk("R1", "reset done", 64'(done_o), 64'(0));
    chk("R1", "reset inc", 64'(inc_o), 64'(0));
    chk("R1", "reset wr_en", 64'(wr_en_o), 64'(0));
    @(negedge clk);
    rst_ni = 1'b1;
    m_beat = 0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] rv;
    rv = 64'hA1B2C3D4_85868788;
    do_reset();
    // R4 long loads both byte orders, with a paused beat (R9)
    cyc(1,1,0,1,0,1,32'h1111_2222,rv);
    cyc(1,1,0,1,0,1,32'h3333_4444,rv);
    cyc(1,1,0,1,0,0,32'h5555_6666,rv);
    cyc(0,1,0,1,0,0,32'h0,rv);
    cyc(1,1,0,1,0,0,32'h7777_8888,rv);
    // R5 long stores
    cyc(1,1,1,1,0,1,32'h0,rv);
    cyc(1,1,1,1,0,1,32'h0,rv);
    cyc(1,1,1,1,0,0,32'h0,rv);
    cyc(1,1,1,1,0,0,32'h0,rv);
    // R2 non-data aborts a long access
    cyc(1,1,0,1,0,0,32'hDEAD_BEEF,rv);
    cyc(1,0,0,1,0,0,32'h0,rv);
    cyc(1,1,0,1,0,0,32'hCAFE_F00D,rv);
    cyc(1,1,0,1,0,0,32'hCAFE_F00E,rv);
    // R6 R7 short loads, sign bit both values
    cyc(1,1,0,0,1,0,32'h3F80_0000,rv);
    cyc(1,1,0,0,0,0,32'h8000_0001,rv);
    cyc(1,1,0,0,0,1,32'h7FFF_FFFF,rv);
    // R8 short stores
    cyc(1,1,1,0,1,0,32'h0,rv);
    cyc(1,1,1,0,0,1,32'h0,rv);
    // R10 short access mid-long restarts the sequence
    cyc(1,1,0,1,0,1,32'h0102_0304,rv);
    cyc(1,1,0,0,0,1,32'h0000_0005,rv);
    cyc(1,1,0,1,0,1,32'h0607_0809,rv);
    // R1 reset in the middle of a long access
    do_reset();
    cyc(1,1,0,1,0,0,32'hABCD_0001,rv);
    do_reset();
    cyc(1,1,0,1,0,0,32'hABCD_0002,rv);
    cyc(1,1,0,1,0,0,32'hABCD_0003,rv);
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 8) != 0, ($urandom % 8) != 0, $urandom % 2, ($urandom % 3) != 0,
          $urandom % 2, $urandom % 2, $urandom, {$urandom, $urandom});
    end
    finish_run();
  end
endmodule